// File: doc/BRIEF.md
# GPIO Port Register Bank

This block is a parameterised general-purpose I/O port with a small processor register interface. Software programs a direction mask and an output/pull-up mask. It can also flip any set of output bits in one write, by writing ones to the address that reads the pins. For each bit, the block decodes these masks into three pad controls: output enable, output level and pull-up enable. A system-wide pull-up disable input can suppress every pull-up at once.

External pin levels pass through a two-flop synchronizer before they can be read. A pin change therefore reaches the read data after one to two clock cycles. Pins are readable whatever their direction, so a driven output can be read back through the same path. Each cycle allows only one register write. A pin that moves between tri-state and driven-high, or between pulled-up input and driven-low, therefore always passes through one of the two intermediate pad states.

Top module: `gpio_port_bank`

## Requirements
- R1: After reset (rst_n low), the direction and output registers hold 0, all three pad outputs are 0, and the synchronizer stages hold 0.
- R2: A write to address 1 loads the direction register. The new value appears on pad_oe and on reads of address 1 from the next rising clock edge.
- R3: A write to address 2 loads the output register. The new value appears on pad_out and on reads of address 2 from the next rising clock edge.
- R4: A write to address 0 inverts each output-register bit whose write-data bit is 1 and leaves bits written 0 unchanged, whatever the direction register holds.
- R5: For each bit, pad_pullup is 1 exactly when the direction bit is 0, the output bit is 1, and pud_all is 0.
- R6: pad_pullup is 0 on every bit whose direction bit is 1, whatever the value of pud_all.
- R7: A read of address 0 returns pin_in delayed by two flop stages. A level that is applied before rising edge k and held is returned from edge k+1 onward, whatever the direction register holds.
- R8: rdata is 0 when rd_en is 0 or when address 3 is read. A write to address 3 changes no register.
- R9: In a cycle with no write, pad_oe and pad_out hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read enable |
| addr | input | 2 | Register select: 0 pins/toggle, 1 direction, 2 output, 3 unused |
| wdata | input | WIDTH | Write data |
| rdata | output | WIDTH | Read data (combinational) |
| pud_all | input | 1 | Global pull-up disable |
| pin_in | input | WIDTH | External pin levels (asynchronous) |
| pad_oe | output | WIDTH | Per-bit output enable |
| pad_out | output | WIDTH | Per-bit output level |
| pad_pullup | output | WIDTH | Per-bit pull-up enable |

## Verification
The toggle address receives mixed masks both while pins are inputs and while they are outputs. A design that overwrote instead of inverting, or that gated the flip with the direction bit, would leave the wrong pad_out. Pull-up decoding is exercised with pud_all set, with pins switched to output, and with a write to the unused address. A leaky decode would raise a pull-up on a driven pin, and a decoder that aliased address 3 would corrupt a register. The input path is sampled one edge and two edges after a pin change. A single-stage or three-stage synchronizer shows up as early or late read data.

// File: rtl/gpio_port_bank.sv
module gpio_port_bank #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [1:0]       addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata,
  input  logic             pud_all,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_pullup
);

  localparam logic [1:0] A_PIN = 2'd0;
  localparam logic [1:0] A_DIR = 2'd1;
  localparam logic [1:0] A_OUT = 2'd2;

  logic [WIDTH-1:0] dir_q, out_q, sync1_q, sync2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      out_q <= '0;
    end else if (wr_en) begin
      case (addr)
        A_DIR:   dir_q <= wdata;
        A_OUT:   out_q <= wdata;
        A_PIN:   out_q <= out_q ^ wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
    end
  end

  assign pad_oe     = dir_q;
  assign pad_out    = out_q;
  assign pad_pullup = ~dir_q & out_q & {WIDTH{~pud_all}};

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        A_PIN:   rdata = sync2_q;
        A_DIR:   rdata = dir_q;
        A_OUT:   rdata = out_q;
        default: rdata = '0;
      endcase
    end
  end

  logic [1:0] live_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live_cnt <= '0;
    else if (live_cnt != 2'd2) live_cnt <= live_cnt + 2'd1;
  end

  // R4
  toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_PIN) |=> pad_out == ($past(pad_out) ^ $past(wdata)));

  // R6
  no_pullup_on_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & pad_pullup) == '0);

  // R5
  pud_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pud_all |-> pad_pullup == '0);

  // R7
  sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_PIN && live_cnt == 2'd2) |-> rdata == $past(pin_in, 2));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(pad_oe) && $stable(pad_out)));

  // R8
  unused_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd3) |=> ($stable(pad_oe) && $stable(pad_out)));

endmodule

// File: tb/tb_gpio_port_bank.sv
`timescale 1ns/1ps
module tb_gpio_port_bank;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n, wr_en, rd_en, pud_all;
  logic [1:0] addr;
  logic [W-1:0] wdata, rdata, pin_in, pad_oe, pad_out, pad_pullup;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  gpio_port_bank #(.WIDTH(W)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pud_all(pud_all), .pin_in(pin_in),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_pullup(pad_pullup));

  // {addr, wdata, pud, exp_oe, exp_out, exp_pu}
  localparam int NV = 8;
  localparam logic [34:0] VEC [NV] = '{
    {2'd2, 8'hF0, 1'b0, 8'h00, 8'hF0, 8'hF0},  // R3 R5
    {2'd1, 8'h3C, 1'b0, 8'h3C, 8'hF0, 8'hC0},  // R2 R6
    {2'd0, 8'h81, 1'b0, 8'h3C, 8'h71, 8'h41},  // R4 mixed dir
    {2'd0, 8'h00, 1'b1, 8'h3C, 8'h71, 8'h00},  // R4 zero mask, R5 pud
    {2'd3, 8'hFF, 1'b0, 8'h3C, 8'h71, 8'h41},  // R8 unused addr
    {2'd1, 8'hFF, 1'b0, 8'hFF, 8'h71, 8'h00},  // R6 all outputs
    {2'd0, 8'hFF, 1'b1, 8'hFF, 8'h8E, 8'h00},  // R4 while driving
    {2'd1, 8'h00, 1'b0, 8'h00, 8'h8E, 8'h8E}   // R5 back to inputs
  };

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [W-1:0] v);
    rd_en = 1'b1; addr = a; #1; v = rdata; rd_en = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] v;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; pud_all = 1'b0;
    addr = '0; wdata = '0; pin_in = 8'h5A;
    repeat (3) @(negedge clk);
    chk("R1 oe", pad_oe, 8'h00);
    chk("R1 out", pad_out, 8'h00);
    chk("R1 pu", pad_pullup, 8'h00);
    rd(2'd0, v); chk("R1 sync", v, 8'h00);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      pud_all = VEC[i][24];
      wr(VEC[i][34:33], VEC[i][32:25]);
      chk("R2/R4/R8 oe", pad_oe, VEC[i][23:16]);
      chk("R3/R4/R8 out", pad_out, VEC[i][15:8]);
      chk("R5/R6 pu", pad_pullup, VEC[i][7:0]);
      rd(2'd1, v); chk("R2 dir readback", v, VEC[i][23:16]);
      rd(2'd2, v); chk("R3 out readback", v, VEC[i][15:8]);
    end

    // R8 read gating
    @(negedge clk); pud_all = 1'b0;
    rd(2'd3, v); chk("R8 addr3 read", v, 8'h00);
    addr = 2'd2; rd_en = 1'b0; #1; chk("R8 rd_en low", rdata, 8'h00);

    // R7 synchronizer latency, pins as inputs
    @(negedge clk); pin_in = 8'hA5; rd_en = 1'b1; addr = 2'd0;
    @(posedge clk); #1; chk("R7 one edge", rdata, 8'h5A);
    @(posedge clk); #1; chk("R7 two edges", rdata, 8'hA5);
    rd_en = 1'b0;

    // R7 readback of driven pins, R9 hold
    wr(2'd1, 8'hFF);
    @(negedge clk); pin_in = pad_out;
    repeat (2) @(negedge clk);
    rd(2'd0, v); chk("R7 output readback", v, 8'h8E);
    repeat (3) @(negedge clk);
    chk("R9 hold oe", pad_oe, 8'hFF);
    chk("R9 hold out", pad_out, 8'h8E);

    // R1 reset mid-run
    @(negedge clk); rst_n = 1'b0; #1;
    chk("R1 rerst oe", pad_oe, 8'h00);
    chk("R1 rerst out", pad_out, 8'h00);
    rd(2'd0, v); chk("R1 rerst sync", v, 8'h00);
    @(negedge clk); rst_n = 1'b1;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule